// File: doc/BRIEF.md
# Physical Register Budget Tracker

This block keeps count of how many rename registers are held in each of several register files while instructions move from dispatch to retirement. File 0 is the global file: every architectural register belongs to it, and it is charged for every allocation made in any file. A register can also be given to one other file, and it carries a weight, so one architectural destination may use more than one physical slot.

Dispatch sends a group of up to four destination registers and gets back, in the same cycle, a bitmask with one bit per file. A set bit means that file has too little room left for the group. When the mask is all zero, dispatch may go ahead and present the same group on the allocate port. At retirement the freed destinations are presented on the free port.

A small write port loads the per-register owner and cost table and the capacity of each file. A capacity of zero means the file has no limit. A request that needs more than a file's whole nonzero capacity can never be met, so it sets a sticky error flag.

Top module: `reg_budget_tracker`

## Requirements
- R1: After a synchronous active-high reset, every used counter reads 0 and `fatal` is 0. Every register belongs to file 0 only, with cost 1. Every capacity is 0.
- R2: A table write stores owner `cfg_reg_file` and cost `cfg_reg_cost` for register `cfg_reg_idx`. A capacity write stores `cfg_cap_val` for file `cfg_cap_file`. Both are in force from the next cycle.
- R3: On allocate, each valid slot adds its register's cost to file 0. It also adds the same cost to the owning file when the owner is nonzero. The new counts appear on `used_cnt` one cycle later. File f's count occupies `used_cnt[10f+9:10f]`.
- R4: On free, each valid slot subtracts its register's cost from file 0, and from the owning file when the owner is nonzero. With no allocate and no free, the counters hold.
- R5: An allocate and a free in the same cycle both take effect in one update. The next cycle's query sees the net count.
- R6: For a query, the costs of the valid slots are summed per file. Slot k uses `q_regs[6k+5:6k]`. `stall_mask[i]` is 1 in the same cycle exactly when used(i) plus that sum is strictly greater than capacity(i). A sum that reaches capacity exactly does not stall.
- R7: A file whose capacity is 0 never sets its stall bit, however large the request.
- R8: A valid query whose per-file sum exceeds a nonzero capacity sets `fatal` on the next cycle. `fatal` stays set until reset.
- R9: When `q_valid` is all zero, `stall_mask` is 0, whatever `q_regs` holds.
- R10: A register named in more than one slot of a group is counted once per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_reg_we | input | 1 | Write enable for the register table |
| cfg_reg_idx | input | 6 | Architectural register to configure |
| cfg_reg_file | input | 2 | Owning file (0 = global only) |
| cfg_reg_cost | input | 8 | Physical slots per definition |
| cfg_cap_we | input | 1 | Write enable for a capacity |
| cfg_cap_file | input | 2 | File whose capacity is written |
| cfg_cap_val | input | 10 | Capacity, 0 = unbounded |
| q_valid | input | 4 | Valid bit per query slot |
| q_regs | input | 24 | Query registers, 6 bits per slot |
| stall_mask | output | 4 | Per-file stall bits for the query |
| alloc_valid | input | 4 | Valid bit per allocate slot |
| alloc_regs | input | 24 | Allocated registers, 6 bits per slot |
| free_valid | input | 4 | Valid bit per free slot |
| free_regs | input | 24 | Freed registers, 6 bits per slot |
| used_cnt | output | 40 | Used counters, 10 bits per file |
| fatal | output | 1 | Sticky error: request can never fit |

## Verification
`stall_mask` is combinational on the query and the stored state, so it is due in the same cycle as the query. The counters, `fatal` and configuration writes each pass through one register and are due after the next rising edge. The bench changes inputs on the falling edge and checks the mask 1 ns later. It then lets one rising edge pass and checks the counters and the flag at the following falling edge, against a model updated for exactly that edge.

// File: rtl/reg_budget_tracker.sv
module reg_budget_tracker #(
  parameter int NFILES = 4,
  parameter int NREGS  = 64,
  parameter int COST_W = 8,
  parameter int CNT_W  = 10,
  parameter int SLOTS  = 4
)(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_reg_we,
  input  logic [$clog2(NREGS)-1:0]  cfg_reg_idx,
  input  logic [$clog2(NFILES)-1:0] cfg_reg_file,
  input  logic [COST_W-1:0]       cfg_reg_cost,
  input  logic                    cfg_cap_we,
  input  logic [$clog2(NFILES)-1:0] cfg_cap_file,
  input  logic [CNT_W-1:0]        cfg_cap_val,
  input  logic [SLOTS-1:0]        q_valid,
  input  logic [SLOTS*$clog2(NREGS)-1:0] q_regs,
  output logic [NFILES-1:0]       stall_mask,
  input  logic [SLOTS-1:0]        alloc_valid,
  input  logic [SLOTS*$clog2(NREGS)-1:0] alloc_regs,
  input  logic [SLOTS-1:0]        free_valid,
  input  logic [SLOTS*$clog2(NREGS)-1:0] free_regs,
  output logic [NFILES*CNT_W-1:0] used_cnt,
  output logic                    fatal
);
  localparam int FW = $clog2(NFILES);
  localparam int RW = $clog2(NREGS);
  localparam int SW = CNT_W + $clog2(SLOTS) + 1;

  logic [FW-1:0]     own_q  [NREGS];
  logic [COST_W-1:0] cost_q [NREGS];
  logic [NFILES-1:0] over_vec;
  logic              fatal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) begin
        own_q[i]  <= '0;
        cost_q[i] <= COST_W'(1);
      end
    end else if (cfg_reg_we) begin
      own_q[cfg_reg_idx]  <= cfg_reg_file;
      cost_q[cfg_reg_idx] <= cfg_reg_cost;
    end
  end

  for (genvar f = 0; f < NFILES; f++) begin : g_file
    logic [CNT_W-1:0] used_q, cap_q;
    logic [SW-1:0]    q_sum, a_sum, f_sum, nxt;

    always_comb begin
      q_sum = '0;
      a_sum = '0;
      f_sum = '0;
      for (int k = 0; k < SLOTS; k++) begin
        if (q_valid[k] && (f == 0 || own_q[q_regs[k*RW +: RW]] == FW'(f)))
          q_sum = q_sum + SW'(cost_q[q_regs[k*RW +: RW]]);
        if (alloc_valid[k] && (f == 0 || own_q[alloc_regs[k*RW +: RW]] == FW'(f)))
          a_sum = a_sum + SW'(cost_q[alloc_regs[k*RW +: RW]]);
        if (free_valid[k] && (f == 0 || own_q[free_regs[k*RW +: RW]] == FW'(f)))
          f_sum = f_sum + SW'(cost_q[free_regs[k*RW +: RW]]);
      end
    end

    assign nxt = SW'(used_q) + a_sum - f_sum;

    always_ff @(posedge clk) begin
      if (rst) begin
        used_q <= '0;
        cap_q  <= '0;
      end else begin
        used_q <= nxt[CNT_W-1:0];
        if (cfg_cap_we && cfg_cap_file == FW'(f))
          cap_q <= cfg_cap_val;
      end
    end

    assign stall_mask[f] = (cap_q != '0) && (SW'(used_q) + q_sum > SW'(cap_q));
    assign over_vec[f]   = (cap_q != '0) && (q_sum > SW'(cap_q));
    assign used_cnt[f*CNT_W +: CNT_W] = used_q;

    assert_over_stalls_R8: assert property (@(posedge clk) disable iff (rst)
      over_vec[f] |-> stall_mask[f]);
  end

  always_ff @(posedge clk) begin
    if (rst)            fatal_q <= 1'b0;
    else if (|over_vec) fatal_q <= 1'b1;
  end
  assign fatal = fatal_q;

  for (genvar f = 1; f < NFILES; f++) begin : g_cover
    assert_global_covers_R3: assert property (@(posedge clk) disable iff (rst)
      used_cnt[f*CNT_W +: CNT_W] <= used_cnt[CNT_W-1:0]);
  end

  assert_fatal_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    fatal |=> fatal);

  assert_fatal_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(fatal) |-> $past(q_valid != '0));

  assert_idle_query_R9: assert property (@(posedge clk) disable iff (rst)
    (q_valid == '0) |-> (stall_mask == '0));

  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (alloc_valid == '0 && free_valid == '0) |=> $stable(used_cnt));
endmodule

// File: tb/reg_budget_tracker_tb_top.sv
`timescale 1ns/1ps
module reg_budget_tracker_tb_top;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_reg_we, cfg_cap_we;
  logic [5:0] cfg_reg_idx;
  logic [1:0] cfg_reg_file, cfg_cap_file;
  logic [7:0] cfg_reg_cost;
  logic [9:0] cfg_cap_val;
  logic [3:0] q_valid, alloc_valid, free_valid, stall_mask;
  logic [23:0] q_regs, alloc_regs, free_regs;
  logic [39:0] used_cnt;
  logic fatal;

  int checks = 0, fails = 0;
  int m_file [64];
  int m_cost [64];
  int m_cap [4];
  int m_used [4];
  bit m_fatal;
  logic [3:0]  qq_v [1024];
  logic [23:0] qq_r [1024];
  int head = 0, tail = 0, depth = 0;

  always #2 clk = ~clk;

  reg_budget_tracker dut_i (
    .clk(clk), .rst(rst),
    .cfg_reg_we(cfg_reg_we), .cfg_reg_idx(cfg_reg_idx), .cfg_reg_file(cfg_reg_file),
    .cfg_reg_cost(cfg_reg_cost), .cfg_cap_we(cfg_cap_we), .cfg_cap_file(cfg_cap_file),
    .cfg_cap_val(cfg_cap_val), .q_valid(q_valid), .q_regs(q_regs), .stall_mask(stall_mask),
    .alloc_valid(alloc_valid), .alloc_regs(alloc_regs), .free_valid(free_valid),
    .free_regs(free_regs), .used_cnt(used_cnt), .fatal(fatal));

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, actual running expected finished");
    summary();
    $finish;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pk(int a, int b, int c, int d);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  function automatic int req(int f, logic [3:0] v, logic [23:0] r);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int reg_id = int'(r[k*6 +: 6]);
      if (v[k] && (f == 0 || m_file[reg_id] == f)) s += m_cost[reg_id];
    end
    return s;
  endfunction

  function automatic logic [3:0] exp_mask(logic [3:0] v, logic [23:0] r);
    logic [3:0] m = '0;
    for (int f = 0; f < 4; f++)
      m[f] = (m_cap[f] != 0) && (m_used[f] + req(f, v, r) > m_cap[f]);
    return m;
  endfunction

  task automatic clear_in();
    cfg_reg_we = 0; cfg_reg_idx = '0; cfg_reg_file = '0; cfg_reg_cost = '0;
    cfg_cap_we = 0; cfg_cap_file = '0; cfg_cap_val = '0;
    q_valid = '0; q_regs = '0; alloc_valid = '0; alloc_regs = '0;
    free_valid = '0; free_regs = '0;
  endtask

  task automatic reset_dut();
    clear_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin m_file[i] = 0; m_cost[i] = 1; end
    for (int f = 0; f < 4; f++) begin m_cap[f] = 0; m_used[f] = 0; end
    m_fatal = 0;
    head = 0; tail = 0; depth = 0;
  endtask

  task automatic step(string tag);
    int nu [4];
    bit over = 0;
    #1;
    chk(tag, "stall_mask", int'(stall_mask), int'(exp_mask(q_valid, q_regs)));
    for (int f = 0; f < 4; f++) begin
      nu[f] = m_used[f] + req(f, alloc_valid, alloc_regs) - req(f, free_valid, free_regs);
      if (m_cap[f] != 0 && req(f, q_valid, q_regs) > m_cap[f]) over = 1;
    end
    @(negedge clk);
    for (int f = 0; f < 4; f++) m_used[f] = nu[f];
    if (over) m_fatal = 1;
    if (cfg_reg_we) begin
      m_file[int'(cfg_reg_idx)] = int'(cfg_reg_file);
      m_cost[int'(cfg_reg_idx)] = int'(cfg_reg_cost);
    end
    if (cfg_cap_we) m_cap[int'(cfg_cap_file)] = int'(cfg_cap_val);
    for (int f = 0; f < 4; f++)
      chk(tag, "used_cnt", int'(used_cnt[f*10 +: 10]), m_used[f]);
    chk(tag, "fatal", int'(fatal), int'(m_fatal));
    clear_in();
  endtask

  task automatic set_cap(int f, int v);
    cfg_cap_we = 1; cfg_cap_file = 2'(f); cfg_cap_val = 10'(v);
    step("R2");
  endtask

  task automatic set_reg(int idx, int f, int c);
    cfg_reg_we = 1; cfg_reg_idx = 6'(idx); cfg_reg_file = 2'(f); cfg_reg_cost = 8'(c);
    step("R2");
  endtask

  initial begin
    void'($urandom(32'd4242));
    reset_dut();
    step("R1");

    set_cap(0, 20); set_cap(1, 4); set_cap(2, 6);
    set_reg(3, 2, 3); set_reg(7, 1, 2); set_reg(9, 3, 5);

    alloc_valid = 4'b0111; alloc_regs = pk(3, 7, 10, 0);
    step("R3");

    q_valid = 4'b0011; q_regs = pk(3, 3, 0, 0);
    step("R10");
    q_valid = 4'b0001; q_regs = pk(7, 0, 0, 0);
    step("R6");
    q_valid = 4'b0011; q_regs = pk(7, 7, 0, 0);
    step("R6");
    q_valid = 4'b1111; q_regs = pk(9, 9, 9, 9);
    step("R7");

    alloc_valid = 4'b0001; alloc_regs = pk(9, 0, 0, 0);
    free_valid = 4'b0001; free_regs = pk(7, 0, 0, 0);
    step("R5");
    q_valid = 4'b0001; q_regs = pk(7, 0, 0, 0);
    step("R5");

    free_valid = 4'b0111; free_regs = pk(3, 10, 9, 0);
    step("R4");
    step("R4");

    q_valid = 4'b0000; q_regs = pk(3, 3, 9, 9);
    step("R9");

    q_valid = 4'b0111; q_regs = pk(3, 3, 3, 0);
    step("R8");
    step("R8");
    step("R8");
    reset_dut();
    step("R1");

    set_cap(0, 400 + int'($urandom % 200));
    for (int f = 1; f < 4; f++)
      set_cap(f, ($urandom % 4 == 0) ? 0 : 40 + int'($urandom % 60));
    for (int i = 0; i < 64; i++)
      set_reg(i, int'($urandom % 4), 1 + int'($urandom % 8));

    for (int n = 0; n < 2000; n++) begin
      logic [3:0] em;
      q_valid = 4'($urandom);
      q_regs = 24'($urandom);
      em = exp_mask(q_valid, q_regs);
      if (em == 0 && q_valid != 0 && ($urandom % 4 != 0) && depth < 1000) begin
        alloc_valid = q_valid; alloc_regs = q_regs;
        qq_v[tail] = q_valid; qq_r[tail] = q_regs;
        tail = (tail + 1) % 1024; depth++;
      end
      if (depth > 0 && (em != 0 || $urandom % 3 == 0) && !(alloc_valid != 0 && depth == 1)) begin
        free_valid = qq_v[head]; free_regs = qq_r[head];
        head = (head + 1) % 1024; depth--;
      end
      step("R6");
    end

    summary();
    $finish;
  end
endmodule